// File: doc/BRIEF.md
# Lattice Coefficient Compress/Decompress Unit

This unit maps polynomial coefficients of a module-lattice key-encapsulation scheme with modulus q = 3329 between their full residue range and short d-bit codes, in either direction. A mode input picks compression (residue to d-bit code) or decompression (d-bit code to residue). A width input gives d, which may be 1, 4, 5, 10 or 11 bits. With d = 1 the same unit turns a noisy coefficient into a message bit, and turns a message bit into 0 or 1665.

Coefficients flow through a three-stage pipeline under a valid/ready handshake, one per clock. Compression avoids a divider. The rounded quotient by q comes from a product with a fixed-point reciprocal of 2q followed by a right shift, and the result is exact for every legal input. A transfer counter marks each 256th result, so a full polynomial can be framed without outside bookkeeping.

Top module: `lattice_coef_codec`

## Requirements
- R1: In compress mode (mode = 0) with a legal width d and input x < 3329, the output equals floor((x*2^(d+1) + 3329) / 6658) mod 2^d, with the error flag low.
- R2: In compress mode, an input whose rounded value reaches 2^d wraps to 0 (for example x = 3328, d = 4 yields 0).
- R3: In decompress mode (mode = 1) the output equals floor((3329*y + 2^(d-1)) / 2^d), where y is the input reduced to its low d bits; with d = 1, y = 1 yields 1665.
- R4: In decompress mode, input bits at positions d and above have no effect on the result.
- R5: A width d outside {1, 4, 5, 10, 11} gives the error flag high and a data value of 0, in either mode.
- R6: In compress mode an input of 3329 or more gives the error flag high and a data value of 0.
- R7: With no backpressure, an item accepted at rising edge k appears at the outputs just after rising edge k+2.
- R8: While outValid is high and outReady is low, inReady is low and outData, outErr and outLast hold their values.
- R9: Every accepted item produces exactly one result, and results leave in the order the items were accepted.
- R10: outLast is high on the 256th, 512th, ... result transfer since reset, and low on all the others.
- R11: During reset outValid and outLast are low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input item present |
| inReady | output | 1 | Unit can accept an item this cycle |
| inMode | input | 1 | 0 = compress, 1 = decompress |
| inBits | input | 4 | Code width d |
| inData | input | 12 | Residue (compress) or code (decompress) |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| outData | output | 12 | Result value |
| outErr | output | 1 | Illegal width or out-of-range residue |
| outLast | output | 1 | Result closes a 256-coefficient polynomial |

## Verification
The assertions assume that the consumer may drop outReady at any time and that inValid is low while reset is asserted. They do not assume that the producer holds its item steady while the unit stalls, because acceptance is decided only at the handshake. The stimulus keeps inValid low during reset. It otherwise toggles both inValid and outReady at random on every cycle, so that stalls at every stage and bubbles between items occur throughout a sweep of all legal residues and codes for each width. That sweep includes codes carrying junk in their high bits.

// File: rtl/lattice_codec_pkg.sv
package lattice_codec_pkg;

  typedef enum logic {
    MODE_SQUEEZE = 1'b0,
    MODE_EXPAND  = 1'b1
  } codecMode_t;

  typedef struct packed {
    logic adv;   // whole pipeline moves one stage this cycle
    logic take;  // an input item is captured into stage 1
  } codecStrobe_t;

  function automatic logic widthAllowed(input logic [3:0] d);
    logic ok;
    case (d)
      4'd1, 4'd4, 4'd5, 4'd10, 4'd11: ok = 1'b1;
      default:                        ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/lattice_codec_dp.sv
module lattice_codec_dp
  import lattice_codec_pkg::*;
#(
  parameter int unsigned Q      = 3329,
  parameter int          COEF_W = 12,
  parameter int          DW     = 4,
  parameter int          MAX_D  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  codecStrobe_t      strobe,
  input  logic              inMode,
  input  logic [DW-1:0]     inBits,
  input  logic [COEF_W-1:0] inData,
  output logic [COEF_W-1:0] outData,
  output logic              outErr
);

  // numerator for compress: x*2^(d+1) + q, largest with x = q-1, d = MAX_D
  localparam int NUM_W   = COEF_W + MAX_D + 1;
  localparam int unsigned DIV2Q = 2 * Q;
  localparam int SHIFT_K = NUM_W + $clog2(DIV2Q);
  localparam longint unsigned RECIP_L = ((64'd1 << SHIFT_K) + 64'(DIV2Q) - 64'd1) / 64'(DIV2Q);
  localparam int RECIP_W = $clog2(RECIP_L + 64'd1);
  localparam int PROD_W  = NUM_W + RECIP_W;

  localparam logic [NUM_W-1:0]  Q_N     = NUM_W'(Q);
  localparam logic [PROD_W-1:0] RECIP_P = PROD_W'(RECIP_L);

  // stage 1: numerator build and legality
  logic [NUM_W-1:0] xWide, dMask, halfUnit, numNext;
  logic             errNext;

  always_comb begin
    xWide    = NUM_W'(inData);
    dMask    = (NUM_W'(1) << inBits) - NUM_W'(1);
    halfUnit = (inBits == '0) ? '0 : (NUM_W'(1) << (inBits - DW'(1)));
    errNext  = !widthAllowed(4'(inBits));
    if (codecMode_t'(inMode) == MODE_SQUEEZE) begin
      if (inData >= COEF_W'(Q)) errNext = 1'b1;
      numNext = (xWide << (inBits + DW'(1))) + Q_N;
    end else begin
      numNext = ((xWide & dMask) * Q_N) + halfUnit;
    end
    if (errNext) numNext = '0;
  end

  logic [NUM_W-1:0] s1Num;
  logic             s1Mode, s1Err;
  logic [DW-1:0]    s1Bits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Num  <= '0;
      s1Mode <= 1'b0;
      s1Err  <= 1'b0;
      s1Bits <= '0;
    end else if (strobe.take) begin
      s1Num  <= numNext;
      s1Mode <= inMode;
      s1Err  <= errNext;
      s1Bits <= inBits;
    end
  end

  // stage 2: reciprocal product for compress, pass-through for decompress
  logic [PROD_W-1:0] s2Val;
  logic              s2Mode, s2Err;
  logic [DW-1:0]     s2Bits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Val  <= '0;
      s2Mode <= 1'b0;
      s2Err  <= 1'b0;
      s2Bits <= '0;
    end else if (strobe.adv) begin
      if (codecMode_t'(s1Mode) == MODE_SQUEEZE)
        s2Val <= PROD_W'(s1Num) * RECIP_P;
      else
        s2Val <= PROD_W'(s1Num);
      s2Mode <= s1Mode;
      s2Err  <= s1Err;
      s2Bits <= s1Bits;
    end
  end

  // stage 3: shift, wrap to d bits, zero on error
  logic [PROD_W-1:0] shifted, wrapped;

  always_comb begin
    if (codecMode_t'(s2Mode) == MODE_SQUEEZE) begin
      shifted = s2Val >> SHIFT_K;
      wrapped = shifted & ((PROD_W'(1) << s2Bits) - PROD_W'(1));
    end else begin
      shifted = s2Val >> s2Bits;
      wrapped = shifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outErr  <= 1'b0;
    end else if (strobe.adv) begin
      outData <= s2Err ? '0 : COEF_W'(wrapped);
      outErr  <= s2Err;
    end
  end

endmodule

// File: rtl/lattice_codec_ctrl.sv
module lattice_codec_ctrl
  import lattice_codec_pkg::*;
#(
  parameter int POLY_N = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output logic         outLast,
  output codecStrobe_t strobe
);

  localparam int STAGES = 3;
  localparam int CNT_W  = $clog2(POLY_N);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(POLY_N - 1);

  logic [STAGES-1:0] vld;
  logic [CNT_W-1:0]  xferCnt;
  logic              adv;

  assign adv         = !vld[STAGES-1] || outReady;
  assign strobe.adv  = adv;
  assign strobe.take = adv && inValid;
  assign inReady     = adv;
  assign outValid    = vld[STAGES-1];
  assign outLast     = vld[STAGES-1] && (xferCnt == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vld <= '0;
    else if (adv) vld <= {vld[STAGES-2:0], inValid};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferCnt <= '0;
    else if (vld[STAGES-1] && outReady)
      xferCnt <= (xferCnt == CNT_TOP) ? '0 : xferCnt + CNT_W'(1);
  end

endmodule

// File: rtl/lattice_coef_codec.sv
module lattice_coef_codec
  import lattice_codec_pkg::*;
#(
  parameter int unsigned Q      = 3329,
  parameter int          COEF_W = 12,
  parameter int          DW     = 4,
  parameter int          MAX_D  = 11,
  parameter int          POLY_N = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inMode,
  input  logic [DW-1:0]     inBits,
  input  logic [COEF_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [COEF_W-1:0] outData,
  output logic              outErr,
  output logic              outLast
);

  codecStrobe_t strobe;

  lattice_codec_ctrl #(.POLY_N(POLY_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .outLast(outLast), .strobe(strobe)
  );

  lattice_codec_dp #(.Q(Q), .COEF_W(COEF_W), .DW(DW), .MAX_D(MAX_D)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inMode(inMode),
    .inBits(inBits), .inData(inData), .outData(outData), .outErr(outErr)
  );

endmodule

// File: rtl/lattice_codec_chk.sv
module lattice_codec_chk #(
  parameter int unsigned Q      = 3329,
  parameter int          COEF_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [COEF_W-1:0] outData,
  input logic              outErr,
  input logic              outLast
);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outErr) && $stable(outLast));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R5 and R6: flagged results carry zero
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outData == '0);

  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outErr |-> outData < COEF_W'(Q));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady, 2) && $past(inReady) |=> outValid);

  assert_last_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> !outLast);

  always @(posedge clk) begin
    if (!rstN) assert_reset_idle_R11: assert (!outValid && !outLast);
  end

endmodule

bind lattice_coef_codec lattice_codec_chk #(.Q(Q), .COEF_W(COEF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .outErr(outErr), .outLast(outLast)
);

// File: tb/lattice_coef_codec_bench.sv
module lattice_coef_codec_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inMode = 1'b0;
  logic [3:0]  inBits = 4'd0;
  logic [11:0] inData = 12'd0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [11:0] outData;
  logic        outErr;
  logic        outLast;

  always #5 clk = ~clk;

  lattice_coef_codec u_lattice_coef_codec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inMode(inMode), .inBits(inBits), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outErr(outErr), .outLast(outLast)
  );

  int nChecks = 0;
  int nErrs   = 0;
  int xferCount = 0;
  int acceptCount = 0;

  int    sMode[$], sD[$], sData[$];
  string sReq[$];
  int    eData[$], eErr[$];
  string eReq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legalWidth(input int d);
    return (d == 1) || (d == 4) || (d == 5) || (d == 10) || (d == 11);
  endfunction

  // reference: R1, R2 (wrap), R3, R4 (masking), R5, R6
  task automatic refModel(input int mode, input int d, input int data,
                          output int err, output int val);
    longint num, y;
    err = 0; val = 0;
    if (!legalWidth(d)) begin err = 1; return; end
    if (mode == 0) begin
      if (data >= 3329) begin err = 1; return; end
      num = longint'(data) * (64'd1 << (d + 1)) + 3329;
      val = int'((num / 6658) % (64'd1 << d));
    end else begin
      y   = longint'(data) % (64'd1 << d);
      val = int'((2 * 3329 * y + (64'd1 << d)) / (64'd1 << (d + 1)));
    end
  endtask

  task automatic addItem(input int mode, input int d, input int data, input string req);
    sMode.push_back(mode); sD.push_back(d); sData.push_back(data); sReq.push_back(req);
  endtask

  int expErr, expVal;
  bit stalled = 0;
  int holdData, holdErr, holdLast;
  int cyc = 0;
  bit outFire, inFire, expLast;

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R11 outValid", int'(outValid), 0);
    check(outLast == 1'b0, "R11 outLast", int'(outLast), 0);
    check(inReady == 1'b1, "R11 inReady", int'(inReady), 1);
    rstN = 1'b1;

    // R7: single item latency with no backpressure
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inMode = 1'b0; inBits = 4'd10; inData = 12'd1000;
    #1 check(inReady == 1'b1, "R7 accept", int'(inReady), 1);
    @(negedge clk); inValid = 1'b0;
    check(outValid == 1'b0, "R7 early k", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b0, "R7 early k+1", int'(outValid), 0);
    @(negedge clk);
    refModel(0, 10, 1000, expErr, expVal);
    check(outValid == 1'b1, "R7 valid at k+2", int'(outValid), 1);
    check(int'(outData) == expVal, "R7 R1 data", int'(outData), expVal);
    xferCount = 1;

    // stimulus build
    foreach (sD[i]) ;
    for (int w = 0; w < 5; w++) begin
      int d;
      d = (w == 0) ? 1 : (w == 1) ? 4 : (w == 2) ? 5 : (w == 3) ? 10 : 11;
      for (int x = 0; x < 3329; x++) begin
        longint raw;
        raw = (longint'(x) * (64'd1 << (d + 1)) + 3329) / 6658;
        addItem(0, d, x, (raw == (64'd1 << d)) ? "R2" : "R1");
      end
      for (int y = 0; y < (1 << d); y++) begin
        addItem(1, d, y, "R3");
        if (y < 8) addItem(1, d, y | ((y + 1) << d) & 12'hFFF, "R4");
      end
    end
    addItem(1, 1, 1, "R3");
    for (int b = 0; b < 16; b++) if (!legalWidth(b)) begin
      addItem(0, b, 100, "R5");
      addItem(1, b, 3, "R5");
    end
    addItem(0, 4, 3329, "R6");
    addItem(0, 11, 3330, "R6");
    addItem(0, 1, 4095, "R6");

    // main loop: random throttling on both sides
    while ((sD.size() > 0 || eData.size() > 0) && cyc < 190000) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        check(outValid == 1'b1, "R8 valid held", int'(outValid), 1);
        check(int'(outData) == holdData && int'(outErr) == holdErr && int'(outLast) == holdLast,
              "R8 outputs held", int'(outData), holdData);
      end
      outReady = ($urandom_range(0, 3) != 0);
      if (sD.size() > 0 && $urandom_range(0, 3) != 0) begin
        inValid = 1'b1;
        inMode  = sMode[0][0];
        inBits  = 4'(sD[0]);
        inData  = 12'(sData[0]);
      end else begin
        inValid = 1'b0;
      end
      #1;
      outFire = outValid && outReady;
      inFire  = inValid && inReady;
      if (outValid && !outReady)
        check(inReady == 1'b0, "R8 inReady low on stall", int'(inReady), 0);
      if (outFire) begin
        expLast = ((xferCount % 256) == 255);
        check(outLast == expLast, "R10 last flag", int'(outLast), int'(expLast));
        xferCount++;
        if (eData.size() == 0) begin
          check(1'b0, "R9 spurious result", int'(outData), -1);
        end else begin
          check(int'(outData) == eData[0], eReq[0], int'(outData), eData[0]);
          check(int'(outErr) == eErr[0], {eReq[0], " err"}, int'(outErr), eErr[0]);
          void'(eData.pop_front()); void'(eErr.pop_front()); void'(eReq.pop_front());
        end
      end
      stalled  = outValid && !outReady;
      holdData = int'(outData); holdErr = int'(outErr); holdLast = int'(outLast);
      if (inFire) begin
        refModel(sMode[0], sD[0], sData[0], expErr, expVal);
        eData.push_back(expVal); eErr.push_back(expErr); eReq.push_back(sReq[0]);
        acceptCount++;
        void'(sMode.pop_front()); void'(sD.pop_front());
        void'(sData.pop_front()); void'(sReq.pop_front());
      end
    end

    if (cyc >= 190000) check(1'b0, "watchdog expired", cyc, 190000);
    check(xferCount == acceptCount + 1, "R9 one result per item", xferCount, acceptCount + 1);
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule